// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single reservation that a core's load-reserved (LR) and store-conditional (SC) instructions share. An aligned LR records its address and access size. A later SC to the same address, with the same size, is allowed to write memory and reports success. Every other case reports failure.

The reservation is dropped in four cases:
- after any SC, whether it passed or failed;
- on a privilege-mode change, so that one context cannot use another context's reservation;
- on an external invalidate pulse, which stands for a conflicting store from another agent;
- on reset.

An empty reservation is held as an all-ones address, so that address zero remains a legal target. All request outputs are combinational and belong to the cycle in which the request is presented. The reservation update takes effect at the following clock edge.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation is empty, so an SC issued before any LR fails. This holds even for an SC to address 0. All outputs are 0 while no request is presented.
- R2: An aligned LR records its address and size as the reservation and replaces any earlier one. An SC to the earlier address then fails, and an SC to the newest address succeeds.
- R3: An aligned SC succeeds when a reservation is held with an equal address and equal size. In the same cycle as the request it then shows `sc_ok`=1, `mem_we`=1 and `sc_result`=0.
- R4: An SC whose address differs from the reserved address fails. It shows `sc_ok`=0, `mem_we`=0 and `sc_result`=1.
- R5: An SC whose size differs from the LR's size fails, even when the addresses are equal. Size encoding: `req_dword`=0 is a 4-byte word and `req_dword`=1 is an 8-byte doubleword.
- R6: Every SC request leaves the reservation empty at the next edge, whether it passed or failed. In the sequence LR, SC, SC to one address, the second SC therefore fails.
- R7: A `priv_change` pulse leaves the reservation empty, so a following SC fails.
- R8: An `inval` pulse leaves the reservation empty. When `inval` coincides with an aligned LR, the LR wins and the reservation holds the LR's address.
- R9: Address 0 is a valid reservation target. An LR to 0 followed by an SC to 0 of the same size succeeds.
- R10: On every SC request, whether it passes, fails or is misaligned, `fence_req` equals {release, acquire}, that is bit 1 = `req_rel` and bit 0 = `req_acq`. In every other cycle `fence_req` is 0.
- R11: Alignment rules:
  - A word access needs `req_addr[1:0]`=0 and a doubleword access needs `req_addr[2:0]`=0.
  - A misaligned LR or SC raises `fault` and never raises `mem_we`.
  - A misaligned SC reports failure and still empties the reservation.
  - A misaligned LR leaves the existing reservation unchanged.
- R12: When `priv_change` coincides with an aligned LR, the reservation ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 1 | 0 = LR, 1 = SC |
| req_addr | input | ADDR_W | Byte address of the access |
| req_dword | input | 1 | 0 = word (4 bytes), 1 = doubleword (8 bytes) |
| req_acq | input | 1 | Acquire ordering bit |
| req_rel | input | 1 | Release ordering bit |
| priv_change | input | 1 | Privilege-mode change pulse |
| inval | input | 1 | External invalidate pulse |
| sc_ok | output | 1 | SC succeeded this cycle |
| sc_result | output | RES_W | Write-back value for an SC: 0 on success, 1 on failure |
| mem_we | output | 1 | Memory write enable for a passing SC |
| fence_req | output | 2 | Ordering fence request {release, acquire} |
| fault | output | 1 | Misaligned request |

## Verification
The bench builds the block with its defaults: ADDR_W=32 and RES_W=64. With 32 address bits, the highest aligned doubleword (0xFFFF_FFF8) sits directly below the all-ones empty marker. A reservation there shows that no aligned address can collide with the marker. Address 0 tests the opposite end. The 64-bit result shows that a failure is reported as exactly 1, with the upper bits zero.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic {
    OP_LR = 1'b0,
    OP_SC = 1'b1
  } resv_op_e;

  // natural alignment: word needs two low zero bits, doubleword three
  function automatic logic addr_aligned(input logic [2:0] low, input logic dword);
    return dword ? (low == 3'b000) : (low[1:0] == 2'b00);
  endfunction

  // ordering request carried by an SC: {release, acquire}
  function automatic logic [1:0] fence_bits(input logic acq, input logic rel);
    return {rel, acq};
  endfunction

endpackage

// File: rtl/resv_decode.sv
module resv_decode
  import resv_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_op,
  input  logic [2:0] addr_low,
  input  logic       req_dword,
  output logic       lr_take,
  output logic       sc_fire,
  output logic       aligned,
  output logic       fault
);

  logic is_lr;

  always_comb begin
    aligned = addr_aligned(addr_low, req_dword);
    is_lr   = req_valid && (req_op == OP_LR);
    sc_fire = req_valid && (req_op == OP_SC);
    lr_take = is_lr && aligned;
    fault   = req_valid && !aligned;
  end

endmodule

// File: rtl/resv_state.sv
module resv_state #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              clear_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_dword,
  output logic [ADDR_W-1:0] resv_addr,
  output logic              resv_dword,
  output logic              resv_live
);

  localparam logic [ADDR_W-1:0] EMPTY = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_addr  <= EMPTY;
      resv_dword <= 1'b0;
    end else if (load_en) begin
      resv_addr  <= load_addr;
      resv_dword <= load_dword;
    end else if (clear_en) begin
      resv_addr  <= EMPTY;
      resv_dword <= 1'b0;
    end
  end

  assign resv_live = (resv_addr != EMPTY);

endmodule

// File: rtl/resv_sc_eval.sv
module resv_sc_eval #(
  parameter int ADDR_W = 32
) (
  input  logic              sc_fire,
  input  logic              aligned,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_dword,
  input  logic [ADDR_W-1:0] resv_addr,
  input  logic              resv_dword,
  input  logic              resv_live,
  output logic              match
);

  always_comb begin
    match = sc_fire && aligned && resv_live &&
            (req_addr == resv_addr) && (req_dword == resv_dword);
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RES_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_dword,
  input  logic              req_acq,
  input  logic              req_rel,
  input  logic              priv_change,
  input  logic              inval,
  output logic              sc_ok,
  output logic [RES_W-1:0]  sc_result,
  output logic              mem_we,
  output logic [1:0]        fence_req,
  output logic              fault
);

  // named internal events
  logic              lr_take;
  logic              sc_fire;
  logic              aligned;
  logic              load_en;
  logic              clear_en;
  logic              match;
  logic [ADDR_W-1:0] resv_addr;
  logic              resv_dword;
  logic              resv_live;

  resv_decode u_dec (
    .req_valid (req_valid),
    .req_op    (req_op),
    .addr_low  (req_addr[2:0]),
    .req_dword (req_dword),
    .lr_take   (lr_take),
    .sc_fire   (sc_fire),
    .aligned   (aligned),
    .fault     (fault)
  );

  // privilege change beats a coinciding LR; LR beats SC and invalidate
  assign load_en  = lr_take && !priv_change;
  assign clear_en = priv_change || sc_fire || inval;

  resv_state #(.ADDR_W(ADDR_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .clear_en   (clear_en),
    .load_addr  (req_addr),
    .load_dword (req_dword),
    .resv_addr  (resv_addr),
    .resv_dword (resv_dword),
    .resv_live  (resv_live)
  );

  resv_sc_eval #(.ADDR_W(ADDR_W)) u_eval (
    .sc_fire    (sc_fire),
    .aligned    (aligned),
    .req_addr   (req_addr),
    .req_dword  (req_dword),
    .resv_addr  (resv_addr),
    .resv_dword (resv_dword),
    .resv_live  (resv_live),
    .match      (match)
  );

  always_comb begin
    sc_ok     = match;
    mem_we    = match;
    sc_result = '0;
    if (sc_fire && !match) sc_result[0] = 1'b1;
    fence_req = sc_fire ? fence_bits(req_acq, req_rel) : 2'b00;
  end

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_acq,
  input logic              req_rel,
  input logic              priv_change,
  input logic              sc_ok,
  input logic              mem_we,
  input logic [1:0]        fence_req,
  input logic              fault,
  input logic              lr_take,
  input logic              sc_fire,
  input logic              resv_live,
  input logic [ADDR_W-1:0] resv_addr
);

  p_sc_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fire |=> !resv_live);

  p_priv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    priv_change |=> !resv_live);

  p_lr_records_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_take && !priv_change) |=> (resv_live && resv_addr == $past(req_addr)));

  p_write_needs_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (sc_ok && req_valid && req_op));

  p_fault_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_we);

  p_fence_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req == ((req_valid && req_op) ? {req_rel, req_acq} : 2'b00));

endmodule

bind resv_monitor resv_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .req_acq     (req_acq),
  .req_rel     (req_rel),
  .priv_change (priv_change),
  .sc_ok       (sc_ok),
  .mem_we      (mem_we),
  .fence_req   (fence_req),
  .fault       (fault),
  .lr_take     (lr_take),
  .sc_fire     (sc_fire),
  .resv_live   (resv_live),
  .resv_addr   (resv_addr)
);

// File: tb/resv_monitor_test.sv
module resv_monitor_test;

  localparam int ADDR_W = 32;
  localparam int RES_W  = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_op, req_dword, req_acq, req_rel;
  logic [ADDR_W-1:0] req_addr;
  logic              priv_change, inval;
  logic              sc_ok, mem_we, fault;
  logic [RES_W-1:0]  sc_result;
  logic [1:0]        fence_req;

  int checks = 0;
  int errors = 0;

  // values captured mid-cycle by the op task
  logic             s_ok, s_we, s_fault;
  logic [RES_W-1:0] s_res;
  logic [1:0]       s_fence;

  always #10 clk = ~clk;  // 50 MHz

  resv_monitor #(.ADDR_W(ADDR_W), .RES_W(RES_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_dword(req_dword), .req_acq(req_acq),
    .req_rel(req_rel), .priv_change(priv_change), .inval(inval),
    .sc_ok(sc_ok), .sc_result(sc_result), .mem_we(mem_we),
    .fence_req(fence_req), .fault(fault)
  );

  task automatic check(input longint act, input longint exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_op = 0; req_addr = '0; req_dword = 0;
    req_acq = 0; req_rel = 0; priv_change = 0; inval = 0;
  endtask

  // one cycle: op 0=LR 1=SC, optional side pulses
  task automatic op(input logic o, input logic [ADDR_W-1:0] a, input logic dw,
                    input logic aq, input logic rl, input logic pc, input logic iv);
    @(negedge clk);
    req_valid = 1; req_op = o; req_addr = a; req_dword = dw;
    req_acq = aq; req_rel = rl; priv_change = pc; inval = iv;
    #5;
    s_ok = sc_ok; s_we = mem_we; s_fault = fault; s_res = sc_result; s_fence = fence_req;
    @(posedge clk);
    #1 idle_inputs();
  endtask

  task automatic pulse(input logic pc, input logic iv);
    @(negedge clk);
    priv_change = pc; inval = iv;
    @(posedge clk);
    #1 idle_inputs();
  endtask

  task automatic lr(input logic [ADDR_W-1:0] a, input logic dw, input string tag);
    op(1'b0, a, dw, 1'b0, 1'b0, 1'b0, 1'b0);
    check(s_fault, 0, {tag, " LR fault"});
    check(s_we, 0, {tag, " LR write"});
  endtask

  task automatic sc(input logic [ADDR_W-1:0] a, input logic dw, input logic aq,
                    input logic rl, input logic exp_ok, input string tag);
    op(1'b1, a, dw, aq, rl, 1'b0, 1'b0);
    check(s_ok, exp_ok, {tag, " sc_ok"});
    check(s_we, exp_ok, {tag, " mem_we"});
    check(s_res, exp_ok ? 0 : 1, {tag, " sc_result"});
    check(s_fence, {rl, aq}, {tag, " fence_req R10"});
    check(s_fault, 0, {tag, " fault"});
  endtask

  task automatic t_reset();
    #5;
    check(sc_ok, 0, "R1 idle sc_ok");
    check(mem_we, 0, "R1 idle mem_we");
    check(fault, 0, "R1 idle fault");
    check(fence_req, 0, "R1 idle fence");
    check(sc_result, 0, "R1 idle result");
    sc(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 SC to 0 after reset");
  endtask

  task automatic t_basic();
    lr(32'h100, 1'b0, "R3");
    sc(32'h100, 1'b0, 1'b1, 1'b0, 1'b1, "R3 matching SC");
  endtask

  task automatic t_lr_sc_sc();
    lr(32'h40, 1'b0, "R6");
    sc(32'h40, 1'b0, 1'b1, 1'b1, 1'b1, "R6 first SC");
    sc(32'h40, 1'b0, 1'b0, 1'b0, 1'b0, "R6 second SC");
  endtask

  task automatic t_mismatch();
    lr(32'h80, 1'b0, "R4");
    sc(32'h84, 1'b0, 1'b0, 1'b1, 1'b0, "R4 other address");
    sc(32'h80, 1'b0, 1'b0, 1'b0, 1'b0, "R6 after failed SC");
  endtask

  task automatic t_replace();
    lr(32'h10, 1'b0, "R2");
    lr(32'h20, 1'b0, "R2");
    sc(32'h20, 1'b0, 1'b0, 1'b0, 1'b1, "R2 newest address");
    lr(32'h10, 1'b0, "R2");
    lr(32'h20, 1'b0, "R2");
    sc(32'h10, 1'b0, 1'b0, 1'b0, 1'b0, "R2 replaced address");
  endtask

  task automatic t_size();
    lr(32'h200, 1'b1, "R5");
    sc(32'h200, 1'b0, 1'b0, 1'b0, 1'b0, "R5 word SC after dword LR");
    lr(32'h208, 1'b0, "R5");
    sc(32'h208, 1'b1, 1'b0, 1'b0, 1'b0, "R5 dword SC after word LR");
  endtask

  task automatic t_priv();
    lr(32'h300, 1'b0, "R7");
    pulse(1'b1, 1'b0);
    sc(32'h300, 1'b0, 1'b0, 1'b0, 1'b0, "R7 SC after priv change");
    op(1'b0, 32'h310, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    sc(32'h310, 1'b0, 1'b0, 1'b0, 1'b0, "R12 LR with priv change");
  endtask

  task automatic t_inval();
    lr(32'h500, 1'b1, "R8");
    pulse(1'b0, 1'b1);
    sc(32'h500, 1'b1, 1'b0, 1'b0, 1'b0, "R8 SC after invalidate");
    op(1'b0, 32'h510, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    sc(32'h510, 1'b1, 1'b0, 1'b0, 1'b1, "R8 LR wins over invalidate");
  endtask

  task automatic t_zero();
    lr(32'h0, 1'b1, "R9");
    sc(32'h0, 1'b1, 1'b1, 1'b1, 1'b1, "R9 address zero");
  endtask

  task automatic t_high();
    lr(32'hFFFF_FFF8, 1'b1, "R9 top");
    sc(32'hFFFF_FFF8, 1'b1, 1'b0, 1'b0, 1'b1, "R9 top aligned dword");
  endtask

  task automatic t_misalign();
    lr(32'h600, 1'b0, "R11");
    op(1'b0, 32'h602, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(s_fault, 1, "R11 misaligned LR fault");
    check(s_we, 0, "R11 misaligned LR write");
    sc(32'h600, 1'b0, 1'b0, 1'b0, 1'b1, "R11 reservation kept");
    lr(32'h700, 1'b1, "R11");
    op(1'b1, 32'h704, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check(s_fault, 1, "R11 misaligned SC fault");
    check(s_we, 0, "R11 misaligned SC write");
    check(s_ok, 0, "R11 misaligned SC ok");
    check(s_res, 1, "R11 misaligned SC result");
    check(s_fence, 2'b01, "R10 misaligned SC fence");
    sc(32'h700, 1'b1, 1'b0, 1'b0, 1'b0, "R11 cleared by misaligned SC");
  endtask

  initial begin
    #4_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_lr_sc_sc();
    t_mismatch();
    t_replace();
    t_size();
    t_priv();
    t_inval();
    t_zero();
    t_high();
    t_misalign();
    repeat (2) @(posedge clk);
    summary();
    $finish;
  end

endmodule